// File: doc/BRIEF.md
# Time-to-Digital Converter Readout Event Decoder

This block takes the 32-bit words that a time-to-digital converter emits during readout and turns them into decoded hits and framing verdicts. Words arrive on a valid/ready handshake. The decoder never stalls the stream, so `in_ready` stays high and a word is taken on every clock edge where `in_valid` is high. The top four bits of each word give its packet type. Bits 27:24 hold the programmable 4-bit chip ID.

A small state machine follows the event framing. It has two states:
- `ST_IDLE`: no event is open.
- `ST_OPEN`: an event header has been seen and its trailer is awaited.

It has three named transitions:
- *open*: `ST_IDLE` to `ST_OPEN`, on a header.
- *restart*: `ST_OPEN` to `ST_OPEN`, on a header that arrives while an event is open. This is a framing error, and the new header starts a new event.
- *close*: `ST_OPEN` to `ST_IDLE`, on a trailer.

All other words leave the state unchanged.

Leading- and trailing-edge hits are unpacked into chip, channel, edge and time. The unpacking has two layouts, chosen by `hires_mode`. At close, the count, event number and ID carried by the trailer are checked against what the decoder observed. Error-report words add their flags to a sticky status register. Every output is registered, so each result appears one cycle after the word is accepted.

Top module: `tdc_evt_decoder`

## Requirements
- R1: A word whose bit 31 is set, or whose type field (bits 31:28) is 0 or 1, pulses `proto_err` for one cycle after acceptance. The word otherwise has no effect: it is not counted and does not change framing.
- R2: Padding words (type 7) have no effect on any output, on the word count or on the framing state.
- R3: With `hires_mode`=0, a type 4 (leading) or type 5 (trailing) word accepted inside an open event produces `hit_valid` one cycle later, with these fields:
  - `hit_edge` = 0 for type 4 and 1 for type 5
  - `hit_chip` = bits 27:24
  - `hit_chan` = bits 23:19
  - `hit_time` = bits 18:0, zero-extended to 21 bits
- R4: With `hires_mode`=1, a hit word decodes as follows:
  - `hit_chan` = bits 23:21 multiplied by 4
  - `hit_time[1:0]` = bits 20:19
  - `hit_time[20:2]` = bits 18:0
- R5: A header (type 2) opens an event. The header carries the event number in bits 23:12 and the chip ID in bits 27:24. A trailer (type 3) in an open event closes it and pulses `evt_done` one cycle later. `evt_ok` is high with that pulse exactly when all of the R6 and R7 checks pass.
- R6: The word count is the number of non-padding, legal words from the header to the trailer, both included. If this differs from the trailer's bits 11:0, `evt_ok` stays low and `frame_err` is set.
- R7: If the trailer's event number (bits 23:12) or chip ID differs from the header's, `evt_ok` stays low and `frame_err` is set.
- R8: A hit, error or trailer word accepted while no event is open sets `frame_err`. It produces no `hit_valid` and no `evt_done`. The decoder waits for the next header.
- R9: A header accepted while an event is open sets `frame_err` and starts a new event from that header, with its count restarted.
- R10: An error word (type 6) inside an open event ORs its bits 14:0 into `err_flags`, with bit 14 always masked to 0. `size_limit` reflects flag bit 12 and `evt_lost` reflects flag bit 13.
- R11: `frame_err` and `err_flags` are sticky until reset. After reset every output is 0 except `in_ready`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hires_mode | input | 1 | 1 selects the very-high-resolution hit layout |
| in_valid | input | 1 | Readout word is valid |
| in_data | input | 32 | Readout word |
| in_ready | output | 1 | Decoder accepts a word (always 1 out of reset) |
| hit_valid | output | 1 | Decoded hit present for one cycle |
| hit_edge | output | 1 | 0 leading edge, 1 trailing edge |
| hit_chip | output | 4 | Chip ID of the hit |
| hit_chan | output | 5 | Channel number |
| hit_time | output | 21 | Time measurement |
| evt_done | output | 1 | Event closed by a trailer, one-cycle pulse |
| evt_ok | output | 1 | Event passed all trailer checks, valid with evt_done |
| frame_err | output | 1 | Sticky framing error |
| proto_err | output | 1 | Illegal word type seen, one-cycle pulse |
| err_flags | output | 15 | Sticky OR of reported error flags, bit 14 masked |
| size_limit | output | 1 | Event size limit reported |
| evt_lost | output | 1 | Trigger overflow (event lost) reported |

## Verification
Suppose the framing state is wrong, for example the state machine believes an event is open when it is not. This shows at the ports one cycle after the next hit or trailer. Either `hit_valid` appears or fails to appear, or `frame_err` rises when it should not. A count that is off by one shows on the very next trailer as `evt_ok` low together with `frame_err` high. A bad header capture shows the same way, one cycle after the trailer. Decoding faults show on the cycle after each hit, as a channel or time that differs from the value rebuilt from the word's fields in the selected layout.

// File: rtl/tdc_evt_pkg.sv
package tdc_evt_pkg;
    localparam int WORD_W    = 32;
    localparam int ID_W      = 4;
    localparam int EVN_W     = 12;
    localparam int CNT_W     = 12;
    localparam int CHAN_W    = 5;
    localparam int NTIME_W   = 19;
    localparam int TIME_W    = NTIME_W + 2;
    localparam int HCH_W     = 3;
    localparam int FLAG_W    = 15;
    localparam int FATAL_BIT = 14;
    localparam int SIZE_BIT  = 12;
    localparam int LOST_BIT  = 13;
    localparam int ID_LSB    = WORD_W - 8;
    localparam int EVN_LSB   = CNT_W;

    typedef enum logic [2:0] {
        K_ILLEGAL, K_HEADER, K_TRAILER, K_LEAD, K_TRAIL, K_ERROR, K_PAD
    } kind_t;

    typedef enum logic {ST_IDLE, ST_OPEN} fstate_t;
endpackage

// File: rtl/tdc_word_class.sv
module tdc_word_class
    import tdc_evt_pkg::*;
(
    input  logic [3:0] type_fld,
    output kind_t      kind
);
    always_comb begin
        unique case (type_fld)
            4'h2:    kind = K_HEADER;
            4'h3:    kind = K_TRAILER;
            4'h4:    kind = K_LEAD;
            4'h5:    kind = K_TRAIL;
            4'h6:    kind = K_ERROR;
            4'h7:    kind = K_PAD;
            default: kind = K_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/tdc_hit_unpack.sv
module tdc_hit_unpack
    import tdc_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                hires,
    input  logic [WORD_W-4:0]   word,
    output logic                hit_valid,
    output logic                hit_edge,
    output logic [ID_W-1:0]     hit_chip,
    output logic [CHAN_W-1:0]   hit_chan,
    output logic [TIME_W-1:0]   hit_time
);
    logic [CHAN_W-1:0] chan_d;
    logic [TIME_W-1:0] time_d;

    always_comb begin
        if (hires) begin
            chan_d = {word[ID_LSB-1 -: HCH_W], 2'b00};
            time_d = {word[NTIME_W-1:0], word[NTIME_W+1:NTIME_W]};
        end else begin
            chan_d = word[ID_LSB-1 -: CHAN_W];
            time_d = {2'b00, word[NTIME_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid <= 1'b0;
            hit_edge  <= 1'b0;
            hit_chip  <= '0;
            hit_chan  <= '0;
            hit_time  <= '0;
        end else begin
            hit_valid <= take;
            if (take) begin
                hit_edge <= word[WORD_W-4];
                hit_chip <= word[ID_LSB +: ID_W];
                hit_chan <= chan_d;
                hit_time <= time_d;
            end
        end
    end
endmodule

// File: rtl/tdc_frame_fsm.sv
module tdc_frame_fsm
    import tdc_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  kind_t              kind,
    input  logic [ID_LSB+ID_W-1:0] word,
    output logic               hit_take,
    output logic               evt_done,
    output logic               evt_ok,
    output logic               frame_err,
    output logic               proto_err,
    output logic [FLAG_W-1:0]  err_flags
);
    localparam logic [FLAG_W-1:0] FLAG_MASK = ~(FLAG_W'(1) << FATAL_BIT);

    fstate_t            state, state_nx;
    logic [EVN_W-1:0]   hdr_evn;
    logic [ID_W-1:0]    hdr_id;
    logic [CNT_W-1:0]   wcount;
    logic [CNT_W-1:0]   cnt_inc;
    logic               is_open;
    logic               trl_match;

    assign is_open   = (state == ST_OPEN);
    assign cnt_inc   = wcount + CNT_W'(1);
    assign hit_take  = fire && is_open && (kind == K_LEAD || kind == K_TRAIL);
    assign trl_match = (word[CNT_W-1:0] == cnt_inc)
                    && (word[EVN_LSB +: EVN_W] == hdr_evn)
                    && (word[ID_LSB +: ID_W] == hdr_id);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: open, restart, close
    always_comb begin
        state_nx = state;
        if (fire) begin
            unique case (state)
                ST_IDLE: if (kind == K_HEADER)  state_nx = ST_OPEN;
                ST_OPEN: if (kind == K_TRAILER) state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs and event bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_done  <= 1'b0;
            evt_ok    <= 1'b0;
            frame_err <= 1'b0;
            proto_err <= 1'b0;
            err_flags <= '0;
            hdr_evn   <= '0;
            hdr_id    <= '0;
            wcount    <= '0;
        end else begin
            evt_done  <= 1'b0;
            evt_ok    <= 1'b0;
            proto_err <= 1'b0;
            if (fire) begin
                unique case (kind)
                    K_ILLEGAL: proto_err <= 1'b1;
                    K_HEADER: begin
                        if (is_open) frame_err <= 1'b1;
                        hdr_evn <= word[EVN_LSB +: EVN_W];
                        hdr_id  <= word[ID_LSB +: ID_W];
                        wcount  <= CNT_W'(1);
                    end
                    K_TRAILER: begin
                        if (!is_open) begin
                            frame_err <= 1'b1;
                        end else begin
                            evt_done <= 1'b1;
                            evt_ok   <= trl_match;
                            if (!trl_match) frame_err <= 1'b1;
                        end
                    end
                    K_LEAD, K_TRAIL: begin
                        if (is_open) wcount <= cnt_inc;
                        else         frame_err <= 1'b1;
                    end
                    K_ERROR: begin
                        if (is_open) begin
                            wcount    <= cnt_inc;
                            err_flags <= err_flags | (word[FLAG_W-1:0] & FLAG_MASK);
                        end else begin
                            frame_err <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tdc_evt_decoder.sv
module tdc_evt_decoder
    import tdc_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hires_mode,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    output logic                in_ready,
    output logic                hit_valid,
    output logic                hit_edge,
    output logic [ID_W-1:0]     hit_chip,
    output logic [CHAN_W-1:0]   hit_chan,
    output logic [TIME_W-1:0]   hit_time,
    output logic                evt_done,
    output logic                evt_ok,
    output logic                frame_err,
    output logic                proto_err,
    output logic [FLAG_W-1:0]   err_flags,
    output logic                size_limit,
    output logic                evt_lost
);
    kind_t kind;
    logic  fire;
    logic  hit_take;

    assign in_ready   = 1'b1;
    assign fire       = in_valid && in_ready;
    assign size_limit = err_flags[SIZE_BIT];
    assign evt_lost   = err_flags[LOST_BIT];

    tdc_word_class u_class (
        .type_fld (in_data[WORD_W-1 -: 4]),
        .kind     (kind)
    );

    tdc_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .kind      (kind),
        .word      (in_data[ID_LSB+ID_W-1:0]),
        .hit_take  (hit_take),
        .evt_done  (evt_done),
        .evt_ok    (evt_ok),
        .frame_err (frame_err),
        .proto_err (proto_err),
        .err_flags (err_flags)
    );

    tdc_hit_unpack u_hit (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (hit_take),
        .hires     (hires_mode),
        .word      (in_data[WORD_W-4:0]),
        .hit_valid (hit_valid),
        .hit_edge  (hit_edge),
        .hit_chip  (hit_chip),
        .hit_chan  (hit_chan),
        .hit_time  (hit_time)
    );
endmodule

// File: rtl/tdc_evt_decoder_chk.sv
module tdc_evt_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hires_mode,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        hit_valid,
    input logic [4:0]  hit_chan,
    input logic        evt_done,
    input logic        evt_ok,
    input logic        frame_err,
    input logic        proto_err,
    input logic [14:0] err_flags
);
    p_proto_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(in_valid && (in_data[31] || in_data[30:29] == 2'b00)));

    p_hit_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(in_valid && in_data[31:29] == 3'b010));

    p_hires_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && $past(hires_mode)) |-> (hit_chan[1:0] == 2'b00));

    p_done_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> $past(in_valid && in_data[31:28] == 4'h3));

    p_ok_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ok |-> evt_done);

    p_bad_event_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && !evt_ok) |-> frame_err);

    p_fatal_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flags[14]);

    p_frame_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(err_flags) & ~err_flags) == 15'h0));
endmodule

bind tdc_evt_decoder tdc_evt_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hires_mode (hires_mode),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .hit_valid  (hit_valid),
    .hit_chan   (hit_chan),
    .evt_done   (evt_done),
    .evt_ok     (evt_ok),
    .frame_err  (frame_err),
    .proto_err  (proto_err),
    .err_flags  (err_flags)
);

// File: tb/tdc_evt_decoder_tb.sv
module tdc_evt_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hires_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, hit_valid, hit_edge;
    logic [3:0]  hit_chip;
    logic [4:0]  hit_chan;
    logic [20:0] hit_time;
    logic        evt_done, evt_ok, frame_err, proto_err, size_limit, evt_lost;
    logic [14:0] err_flags;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tdc_evt_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .hires_mode(hires_mode),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .hit_valid(hit_valid), .hit_edge(hit_edge), .hit_chip(hit_chip),
        .hit_chan(hit_chan), .hit_time(hit_time), .evt_done(evt_done),
        .evt_ok(evt_ok), .frame_err(frame_err), .proto_err(proto_err),
        .err_flags(err_flags), .size_limit(size_limit), .evt_lost(evt_lost)
    );

    function automatic logic [31:0] w_hdr(input logic [3:0] id, input logic [11:0] ev, input logic [11:0] ts);
        return {4'h2, id, ev, ts};
    endfunction
    function automatic logic [31:0] w_trl(input logic [3:0] id, input logic [11:0] ev, input logic [11:0] cnt);
        return {4'h3, id, ev, cnt};
    endfunction
    function automatic logic [31:0] w_hit(input logic trail, input logic [3:0] id, input logic [4:0] ch, input logic [18:0] t);
        return {3'b010, trail, id, ch, t};
    endfunction
    function automatic logic [31:0] w_hhit(input logic trail, input logic [3:0] id, input logic [2:0] ch4,
                                           input logic [1:0] tlo, input logic [18:0] thi);
        return {3'b010, trail, id, ch4, tlo, thi};
    endfunction
    function automatic logic [31:0] w_err(input logic [3:0] id, input logic [14:0] f);
        return {4'h6, id, 9'h0, f};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R11 in_ready", in_ready, 1);
        check("R11 outputs idle", {hit_valid, evt_done, evt_ok, frame_err, proto_err, size_limit, evt_lost}, 0);
        check("R11 err_flags", err_flags, 0);
    endtask

    task automatic t_normal();
        do_reset();
        hires_mode = 1'b0;
        send(w_hdr(4'h1, 12'h005, 12'h0AB));
        check("R5 header no done", evt_done, 0);
        send(w_hit(1'b0, 4'h1, 5'd17, 19'h5A5A5));
        check("R3 lead valid", hit_valid, 1);
        check("R3 lead edge", hit_edge, 0);
        check("R3 lead chip", hit_chip, 4'h1);
        check("R3 lead chan", hit_chan, 17);
        check("R3 lead time", hit_time, 21'h05A5A5);
        send(w_hit(1'b1, 4'h1, 5'd31, 19'h7FFFF));
        check("R3 trail edge", hit_edge, 1);
        check("R3 trail chan", hit_chan, 31);
        check("R3 trail time", hit_time, 21'h07FFFF);
        send(32'h7000_0000);
        check("R2 pad no hit", hit_valid, 0);
        check("R2 pad no err", {frame_err, proto_err}, 0);
        send(w_trl(4'h1, 12'h005, 12'd4));
        check("R5 done", evt_done, 1);
        check("R6 count ok with padding excluded", evt_ok, 1);
        check("R6 no frame err", frame_err, 0);
    endtask

    task automatic t_hires();
        do_reset();
        hires_mode = 1'b1;
        send(w_hdr(4'h3, 12'h0FF, 12'h0));
        send(w_hhit(1'b0, 4'h3, 3'd7, 2'b10, 19'h12345));
        check("R4 hires chan", hit_chan, 28);
        check("R4 hires time", hit_time, {19'h12345, 2'b10});
        send(w_hhit(1'b1, 4'h3, 3'd1, 2'b01, 19'h00000));
        check("R4 hires chan x4", hit_chan, 4);
        check("R4 hires low bits", hit_time, 21'h1);
        send(w_trl(4'h3, 12'h0FF, 12'd4));
        check("R5 hires event ok", {evt_done, evt_ok}, 2'b11);
        hires_mode = 1'b0;
    endtask

    task automatic t_count_bad();
        do_reset();
        send(w_hdr(4'h2, 12'h010, 12'h0));
        send(w_hit(1'b0, 4'h2, 5'd0, 19'h1));
        send(w_trl(4'h2, 12'h010, 12'd4));
        check("R6 bad count done", evt_done, 1);
        check("R6 bad count not ok", evt_ok, 0);
        check("R6 bad count frame_err", frame_err, 1);
        send(32'h7000_0000);
        check("R11 frame_err sticky", frame_err, 1);
    endtask

    task automatic t_hdr_mismatch();
        do_reset();
        send(w_hdr(4'h4, 12'h009, 12'h0));
        send(w_trl(4'h4, 12'h00A, 12'd2));
        check("R7 evnum mismatch", {evt_done, evt_ok, frame_err}, 3'b101);
        do_reset();
        send(w_hdr(4'h4, 12'h009, 12'h0));
        send(w_trl(4'h5, 12'h009, 12'd2));
        check("R7 id mismatch", {evt_done, evt_ok, frame_err}, 3'b101);
    endtask

    task automatic t_outside();
        do_reset();
        send(w_hit(1'b0, 4'h0, 5'd3, 19'h3));
        check("R8 hit outside no valid", hit_valid, 0);
        check("R8 hit outside frame_err", frame_err, 1);
        send(w_trl(4'h0, 12'h0, 12'd1));
        check("R8 trailer outside no done", evt_done, 0);
        do_reset();
        send(w_err(4'h0, 15'h1000));
        check("R8 error outside ignored", {frame_err, size_limit}, 2'b10);
        send(w_hdr(4'h6, 12'h020, 12'h0));
        send(w_trl(4'h6, 12'h020, 12'd2));
        check("R8 resync on header", {evt_done, evt_ok}, 2'b11);
    endtask

    task automatic t_double_hdr();
        do_reset();
        send(w_hdr(4'h7, 12'h001, 12'h0));
        send(w_hit(1'b0, 4'h7, 5'd1, 19'h1));
        send(w_hdr(4'h7, 12'h002, 12'h0));
        check("R9 second header frame_err", frame_err, 1);
        send(w_hit(1'b1, 4'h7, 5'd2, 19'h2));
        check("R9 hit in restarted event", hit_valid, 1);
        send(w_trl(4'h7, 12'h002, 12'd3));
        check("R9 restarted event ok", {evt_done, evt_ok}, 2'b11);
    endtask

    task automatic t_errors();
        do_reset();
        send(w_hdr(4'h8, 12'h030, 12'h0));
        send(w_err(4'h8, 15'h7001));
        check("R10 flags masked", err_flags, 15'h3001);
        check("R10 size_limit", size_limit, 1);
        check("R10 evt_lost", evt_lost, 1);
        send(w_err(4'h8, 15'h0010));
        check("R10 flags accumulate", err_flags, 15'h3011);
        send(w_trl(4'h8, 12'h030, 12'd4));
        check("R10 errors counted", {evt_done, evt_ok}, 2'b11);
        check("R11 flags sticky", err_flags, 15'h3011);
    endtask

    task automatic t_illegal();
        do_reset();
        send(w_hdr(4'h9, 12'h040, 12'h0));
        send(32'h8412_3456);
        check("R1 bit31 proto_err", proto_err, 1);
        send(32'h0000_0001);
        check("R1 type0 proto_err", proto_err, 1);
        send(32'h1000_0000);
        check("R1 type1 proto_err", proto_err, 1);
        check("R1 illegal no hit", hit_valid, 0);
        send(32'h7000_0000);
        check("R1 proto_err pulse", proto_err, 0);
        send(w_trl(4'h9, 12'h040, 12'd2));
        check("R1 illegal not counted", {evt_done, evt_ok, frame_err}, 3'b110);
    endtask

    initial begin
        t_reset_state();
        t_normal();
        t_hires();
        t_count_bad();
        t_hdr_mismatch();
        t_outside();
        t_double_hdr();
        t_errors();
        t_illegal();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule